// File: doc/BRIEF.md
# Limit-Match Interval Timer

This block is a 32-bit interval timer on a small word-addressed register port. A tick input marks each 500 ns period; on every tick the count grows by one unit of bit 9 (0x200), and bits 8..0 of any count value stay zero. Software loads a limit. When the count arrives at a nonzero limit the block raises a sticky reached flag together with a level interrupt, and the next tick brings the count back to zero, so the timer produces a steady period.

A limit of zero puts the timer in free-run: the count climbs to its top value (0x7FFFFE00 at the default width) and wraps to zero without ever flagging. Software acknowledges an event by reading the limit word, which clears both the flag and the interrupt. The limit can be loaded with a restart of the count, or loaded in place so that the running count is kept. Word offsets decode as follows: 0 loads the limit with restart (read: limit and acknowledge), 1 returns the count with the flag, and 2 loads the limit without restart. Every other offset is unimplemented.

Top module: `limit_timer`

## Requirements
- R1: After reset the limit, the count, the reached flag and irq are all zero, so the timer runs free.
- R2: Each cycle with tick high adds 0x200 to the count; with tick low and no restart the count does not change, and count bits 8..0 always read zero.
- R3: With a nonzero limit, the tick that brings the count to the limit sets the reached flag and irq on the same edge; the following tick returns the count to zero.
- R4: irq stays high until a read or write of offset 0; the reached flag stays set until a read of offset 0.
- R5: A write to offset 0 stores wdata & 0x7FFFFE00 as the limit, restarts the count at zero and lowers irq, leaving the reached flag as it was; it wins over a tick in the same cycle.
- R6: A write to offset 2 stores wdata & 0x7FFFFE00 as the limit and keeps the running count.
- R7: With a zero limit the count wraps from its top value (all count bits 30..9 set) to zero and neither the reached flag nor irq is ever set.
- R8: A read of offset 0 returns the limit (bit 31 zero) and clears the reached flag and irq; a match on the same edge wins, leaving both set.
- R9: A read of offset 1 returns the count in bits 30..9 with the reached flag in bit 31.
- R10: A write to offset 1 or to offsets 3 to 7 changes nothing, and a read of offsets 3 to 7 returns zero.
- R11: reg_rdata is registered: it carries the read result from the edge that takes the read strobe and holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One 500 ns period elapsed; counts on this edge |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt on limit match |

## Verification
Every result lands on the clock edge that samples its cause: a tick changes the count, a match raises the flag and irq, a write restarts the count or moves the limit, and a read strobe loads reg_rdata and clears the flag, all with zero extra cycles of latency. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass and checks on the next falling edge, so each comparison sees the state one edge after its cause. Counting runs keep tick high for an exact number of cycles so the expected count is that number times 0x200. The wrap at the top of the count is checked on a second, narrower instance so that it takes 64 ticks instead of four million.

// File: rtl/ltm_pkg.sv
package ltm_pkg;
  localparam int unsigned OFF_LIMIT      = 0;
  localparam int unsigned OFF_COUNT      = 1;
  localparam int unsigned OFF_LIMIT_KEEP = 2;

  typedef struct packed {
    logic wr_limit_rst;
    logic wr_limit_keep;
    logic rd_limit;
  } reg_op_t;
endpackage

// File: rtl/ltm_count.sv
module ltm_count #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_nxt;
  logic             armed;

  assign cnt_inc = count + 1'b1;
  assign armed   = (limit != '0);

  always_comb begin
    cnt_nxt = count;
    hit     = 1'b0;
    if (restart) begin
      cnt_nxt = '0;
    end else if (tick) begin
      if (armed && count == limit) begin
        cnt_nxt = '0;
      end else if (count == TOP) begin
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_inc;
        hit     = armed && (cnt_inc == limit);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_nxt;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !restart) |=> $stable(count)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) restart |=> (count == '0)); // R5
endmodule

// File: rtl/ltm_flags.sv
module ltm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_rd,
  input  logic clr_wr,
  output logic reached,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (hit)         reached <= 1'b1;
      else if (clr_rd) reached <= 1'b0;
      if (hit)                  irq <= 1'b1;
      else if (clr_rd || clr_wr) irq <= 1'b0;
    end
  end

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (irq && !clr_rd && !clr_wr) |=> irq); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (reached && !clr_rd) |=> reached); // R4
endmodule

// File: rtl/ltm_regs.sv
module ltm_regs
  import ltm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 9,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = DATA_W - 1 - FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              reached,
  output logic [CNT_W-1:0]  limit,
  output reg_op_t           op,
  output logic [DATA_W-1:0] reg_rdata
);
  logic is_rd;
  logic is_wr;
  logic wdata_unused;

  assign is_rd = reg_en && !reg_we;
  assign is_wr = reg_en &&  reg_we;
  assign wdata_unused = ^{reg_wdata[DATA_W-1], reg_wdata[FRAC_W-1:0]};

  always_comb begin
    op.wr_limit_rst  = is_wr && (reg_addr == ADDR_W'(OFF_LIMIT));
    op.wr_limit_keep = is_wr && (reg_addr == ADDR_W'(OFF_LIMIT_KEEP));
    op.rd_limit      = is_rd && (reg_addr == ADDR_W'(OFF_LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit <= '0;
    end else if (op.wr_limit_rst || op.wr_limit_keep) begin
      limit <= reg_wdata[FRAC_W +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (is_rd) begin
      if (reg_addr == ADDR_W'(OFF_LIMIT))
        reg_rdata <= {1'b0, limit, {FRAC_W{1'b0}}};
      else if (reg_addr == ADDR_W'(OFF_COUNT))
        reg_rdata <= {reached, count, {FRAC_W{1'b0}}};
      else
        reg_rdata <= '0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !is_rd |=> $stable(reg_rdata)); // R11
  AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) is_rd |=> (reg_rdata[FRAC_W-1:0] == '0)); // R2
endmodule

// File: rtl/limit_timer.sv
module limit_timer
  import ltm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 9,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = DATA_W - 1 - FRAC_W;

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;
  logic             hit;
  logic             reached;
  reg_op_t          op;

  ltm_regs #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .count(count), .reached(reached), .limit(limit), .op(op),
    .reg_rdata(reg_rdata)
  );

  ltm_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(op.wr_limit_rst), .limit(limit),
    .count(count), .hit(hit)
  );

  ltm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_rd(op.rd_limit), .clr_wr(op.wr_limit_rst),
    .reached(reached), .irq(irq)
  );

  AST_FREE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (limit == '0 && !reached) |=> !reached); // R7
  AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n) (reg_en && !reg_we && reg_addr == '0 && !hit) |=> !irq); // R8
  AST_WRITE_LOWERS: assert property (@(posedge clk) disable iff (!rst_n) (reg_en && reg_we && reg_addr == '0) |=> !irq); // R5
endmodule

// File: tb/test_limit_timer.sv
module test_limit_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, n_tick = 1'b0;
  logic        reg_en = 1'b0, n_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] n_rdata;
  logic        irq, n_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_timer i_limit_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  limit_timer #(.DATA_W(16)) i_limit_timer_narrow (
    .clk(clk), .rst_n(rst_n), .tick(n_tick), .reg_en(n_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata[15:0]), .reg_rdata(n_rdata), .irq(n_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] data);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = 3'(off); reg_wdata = data;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input bit narrow, input int off, output logic [31:0] v);
    @(negedge clk);
    if (narrow) n_en = 1'b1; else reg_en = 1'b1;
    reg_we = 1'b0; reg_addr = 3'(off);
    @(negedge clk);
    reg_en = 1'b0; n_en = 1'b0;
    v = narrow ? {16'h0, n_rdata} : reg_rdata;
  endtask

  task automatic ticks(input bit narrow, input int n);
    @(negedge clk);
    if (narrow) n_tick = 1'b1; else tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    tick = 1'b0; n_tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    rd(0, 1, v); chk("R1/R9 count after reset", v, 32'h0);
    rd(0, 0, v); chk("R1 limit after reset", v, 32'h0);
  endtask

  task automatic t_free_count;
    logic [31:0] v;
    ticks(0, 5);
    rd(0, 1, v); chk("R2/R9 five ticks", v, 32'h0000_0A00);
    repeat (6) @(negedge clk);
    rd(0, 1, v); chk("R2 no tick no change", v, 32'h0000_0A00);
    ticks(0, 3);
    chk("R11 rdata holds between reads", reg_rdata, 32'h0000_0A00);
    rd(0, 1, v); chk("R2 eight ticks", v, 32'h0000_1000);
    chk("R7 free-run no irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_match;
    logic [31:0] v;
    wr(0, 32'h8000_0BFF);
    rd(0, 0, v); chk("R5/R8 limit masked", v, 32'h0000_0A00);
    rd(0, 1, v); chk("R5 count restarted", v, 32'h0);
    ticks(0, 4);
    chk("R3 no irq before limit", {31'h0, irq}, 32'h0);
    ticks(0, 1);
    chk("R3 irq at limit", {31'h0, irq}, 32'h1);
    rd(0, 1, v); chk("R3/R9 flag and count at limit", v, 32'h8000_0A00);
    ticks(0, 1);
    rd(0, 1, v); chk("R3/R4 back to zero, flag sticky", v, 32'h8000_0000);
    chk("R4 irq held", {31'h0, irq}, 32'h1);
    wr(1, 32'h1234_5600);
    rd(0, 1, v); chk("R10 write offset 1 ignored", v, 32'h8000_0000);
    wr(5, 32'hFFFF_FFFF);
    rd(0, 3, v); chk("R10 read offset 3 zero", v, 32'h0);
    rd(0, 6, v); chk("R10 read offset 6 zero", v, 32'h0);
    chk("R10 irq untouched", {31'h0, irq}, 32'h1);
    rd(0, 0, v); chk("R10/R8 limit unchanged after offset 5 write", v, 32'h0000_0A00);
    chk("R8 read acknowledges irq", {31'h0, irq}, 32'h0);
    rd(0, 1, v); chk("R8 flag cleared by read", v, 32'h0);
  endtask

  task automatic t_write_ack;
    logic [31:0] v;
    ticks(0, 5);
    chk("R3 second match irq", {31'h0, irq}, 32'h1);
    wr(0, 32'h0000_0A00);
    chk("R5 write lowers irq", {31'h0, irq}, 32'h0);
    rd(0, 1, v); chk("R5 flag kept, count zero", v, 32'h8000_0000);
    rd(0, 0, v);
    rd(0, 1, v); chk("R8 flag cleared", v, 32'h0);
  endtask

  task automatic t_keep;
    logic [31:0] v;
    ticks(0, 3);
    wr(2, 32'h0000_1000);
    rd(0, 1, v); chk("R6 count kept", v, 32'h0000_0600);
    rd(0, 0, v); chk("R6 new limit", v, 32'h0000_1000);
    ticks(0, 5);
    chk("R6 irq at new limit", {31'h0, irq}, 32'h1);
    rd(0, 1, v); chk("R6 flag at new limit", v, 32'h8000_1000);
    rd(0, 0, v);
    chk("R8 ack", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_write_wins;
    logic [31:0] v;
    @(negedge clk);
    tick = 1'b1; reg_en = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_1000;
    @(negedge clk);
    tick = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    rd(0, 1, v); chk("R5 write wins over tick", v, 32'h0);
  endtask

  task automatic t_hit_beats_ack;
    logic [31:0] v;
    wr(0, 32'h0000_0400);
    ticks(0, 1);
    @(negedge clk);
    tick = 1'b1; reg_en = 1'b1; reg_we = 1'b0; reg_addr = 3'd0;
    @(negedge clk);
    tick = 1'b0; reg_en = 1'b0;
    chk("R8 read data with simultaneous match", reg_rdata, 32'h0000_0400);
    chk("R8 match wins irq", {31'h0, irq}, 32'h1);
    rd(0, 1, v); chk("R8 match wins flag", v, 32'h8000_0400);
    rd(0, 0, v);
    chk("R8 later ack", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_free_zero;
    logic [31:0] v;
    wr(0, 32'h0000_0000);
    ticks(0, 100);
    chk("R7 zero limit no irq", {31'h0, irq}, 32'h0);
    rd(0, 1, v); chk("R7 zero limit no flag", v, 32'h0000_C800);
  endtask

  task automatic t_wrap_narrow;
    logic [31:0] v;
    ticks(1, 63);
    rd(1, 1, v); chk("R7 narrow at top", v, 32'h0000_7E00);
    ticks(1, 1);
    rd(1, 1, v); chk("R7 narrow wrapped, no flag", v, 32'h0);
    chk("R7 narrow no irq", {31'h0, n_irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_free_count;
    t_match;
    t_write_ack;
    t_keep;
    t_write_wins;
    t_hit_beats_ack;
    t_free_zero;
    t_wrap_narrow;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule